// File: doc/BRIEF.md
# Sampling Phase Window Picker

The block picks one receive sampling phase out of a set of candidates, given a pass mask with one bit per phase (bit i set means phase i sampled correctly during a sweep). It groups the passing phases into windows of strictly consecutive indices, scanning upwards from phase 0. A window that ends at the top phase and a separate window that starts at phase 0 are treated as one window that wraps around. Among the windows it takes the longest one, and it returns the phase three quarters of the way into it rather than the centre. Placing the pick towards the later edge of the window is deliberate.

A one-cycle `startIn` pulse captures `maskIn`. The block then examines one phase per clock. After a fixed delay it pulses either `validOut` with the chosen phase on `phaseOut`, or `errOut`. Sweeping the phases and programming the delay line are left to the surrounding logic.

Top module: `phase_window_picker`

## Requirements
- R1: After reset, `validOut` and `errOut` are low and `phaseOut` is 0.
- R2: With `NUM_PHASES` = N (default 16), a start accepted at clock edge k produces a one-cycle pulse on exactly one of `validOut`/`errOut` after edge k+N+1. Neither flag is high at any other time.
- R3: A start pulse that arrives while a search is in progress (from the accepting edge through the result edge) is ignored, and its mask has no effect.
- R4: A window is a maximal run of set mask bits at consecutive indices. The longest window is selected. With L its length and S its lowest phase (its first phase in window order), the offset is floor(3L/4), reduced by one when nonzero. The output is phase S + offset.
- R5: When windows tie on length, the one met first while scanning upwards from phase 0 wins.
- R6: When bit 0 and bit N-1 are set but the mask is not all ones, the window that ends at phase N-1 and the window that starts at phase 0 form one window. Its phases run from the start of the upper window through N-1 and then 0 upwards. Its length is the sum of the two, and the output phase wraps modulo N. In ties this merged window ranks after every other window.
- R7: An all-ones mask is a single window of length N. For N = 16 the result is phase 11.
- R8: An empty mask gives `errOut` and sets `phaseOut` to 0. Any internal inconsistency also gives `errOut`: a merged window of N or more phases, or a phase of N or more.
- R9: `validOut` and `errOut` are never high in the same cycle.
- R10: `phaseOut` changes only in a cycle that carries a result pulse, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start pulse, captures maskIn when idle |
| maskIn | input | NUM_PHASES | Pass mask, bit i = phase i passed |
| phaseOut | output | $clog2(NUM_PHASES) | Selected phase |
| validOut | output | 1 | One-cycle pulse, selection succeeded |
| errOut | output | 1 | One-cycle pulse, no usable phase |

## Verification
The hardest case to reach is a tie between the wrap-merged window and an interior window of equal length. The merged window exists only once the final phase has been scanned, and it must still lose the tie. Hand-built masks set both edge runs so that their sum exactly equals an interior run (for example runs 0–1, 4–7 and 14–15). A second set makes the merged run strictly longer, so the output wraps past the top phase. Randomised masks with a bias towards set edge bits cover the remaining combinations. Start pulses issued during a scan check that the mask in flight cannot be disturbed.

// File: rtl/phase_pick_pkg.sv
package phase_pick_pkg;

  // Strobes issued by the sequencer to the window datapath.
  typedef struct packed {
    logic clear;    // capture a new mask and forget all windows
    logic step;     // examine the phase at the current index
    logic resolve;  // pick the window and register the result
  } ctl_strobes_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SCAN    = 2'd1,
    ST_RESOLVE = 2'd2
  } pick_state_t;

endpackage

// File: rtl/phase_pick_ctrl.sv
module phase_pick_ctrl
  import phase_pick_pkg::*;
#(
  parameter int NUM_PHASES = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startIn,
  output ctl_strobes_t                  ctl,
  output logic [$clog2(NUM_PHASES)-1:0] stepIdx
);

  localparam int PW = $clog2(NUM_PHASES);
  localparam logic [PW-1:0] LAST_IDX = PW'(NUM_PHASES - 1);

  pick_state_t state;
  logic [PW-1:0] idxQ;

  always_comb begin
    ctl.clear   = (state == ST_IDLE) && startIn;
    ctl.step    = (state == ST_SCAN);
    ctl.resolve = (state == ST_RESOLVE);
  end

  assign stepIdx = idxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idxQ  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startIn) begin
            state <= ST_SCAN;
            idxQ  <= '0;
          end
        end
        ST_SCAN: begin
          if (idxQ == LAST_IDX) begin
            state <= ST_RESOLVE;
          end else begin
            idxQ <= idxQ + 1'b1;
          end
        end
        ST_RESOLVE: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  // R2
  last_step_resolves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && idxQ == LAST_IDX) |=> ctl.resolve);

  // R3
  start_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && idxQ != LAST_IDX) |=> (ctl.step && !ctl.clear));

endmodule

// File: rtl/phase_pick_dp.sv
module phase_pick_dp
  import phase_pick_pkg::*;
#(
  parameter int NUM_PHASES = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctl_strobes_t                  ctl,
  input  logic [$clog2(NUM_PHASES)-1:0] stepIdx,
  input  logic [NUM_PHASES-1:0]         maskIn,
  output logic [$clog2(NUM_PHASES)-1:0] phaseOut,
  output logic                          validOut,
  output logic                          errOut
);

  localparam int PW = $clog2(NUM_PHASES);
  localparam int LW = $clog2(NUM_PHASES + 1);
  localparam int SW = LW + 3;
  localparam logic [SW-1:0] N_W = SW'(NUM_PHASES);

  logic [NUM_PHASES-1:0] maskQ;
  logic [LW-1:0] curLen, firstLen, midLen;
  logic [PW-1:0] curStart, midStart;
  logic [PW-1:0] phaseQ;
  logic          validQ, errQ;

  // Scan step: extend the open run, or close it on a failing phase.
  logic          bitNow;
  logic [PW-1:0] runStartNow;
  assign bitNow      = maskQ[stepIdx];
  assign runStartNow = (curLen == '0) ? stepIdx : curStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ    <= '0;
      curLen   <= '0;
      curStart <= '0;
      firstLen <= '0;
      midLen   <= '0;
      midStart <= '0;
    end else if (ctl.clear) begin
      maskQ    <= maskIn;
      curLen   <= '0;
      curStart <= '0;
      firstLen <= '0;
      midLen   <= '0;
      midStart <= '0;
    end else if (ctl.step) begin
      if (bitNow) begin
        curStart <= runStartNow;
        curLen   <= curLen + 1'b1;
      end else if (curLen != '0) begin
        if (curStart == '0) begin
          firstLen <= curLen;
        end else if (curLen > midLen) begin
          midLen   <= curLen;
          midStart <= curStart;
        end
        curLen <= '0;
      end
    end
  end

  // Resolve: rank first window, interior best, and the run open at the top.
  logic [LW:0]   mergedLen;
  logic [LW:0]   selLen;
  logic [PW-1:0] selStart;
  logic          mergeErr;

  always_comb begin
    mergedLen = {1'b0, firstLen} + {1'b0, curLen};
    mergeErr  = 1'b0;
    selLen    = '0;
    selStart  = '0;
    if (curLen != '0 && curStart == '0) begin
      // every phase passed: one window beginning at phase 0
      selLen   = {1'b0, curLen};
      selStart = '0;
    end else if (firstLen != '0 && curLen != '0) begin
      // wrap-around: merged window ranks last
      selLen   = {1'b0, midLen};
      selStart = midStart;
      if (mergedLen > selLen) begin
        selLen   = mergedLen;
        selStart = curStart;
      end
      if ({2'b0, mergedLen} >= N_W) mergeErr = 1'b1;
    end else begin
      selLen   = {1'b0, firstLen};
      selStart = '0;
      if ({1'b0, midLen} > selLen) begin
        selLen   = {1'b0, midLen};
        selStart = midStart;
      end
      if ({1'b0, curLen} > selLen) begin
        selLen   = {1'b0, curLen};
        selStart = curStart;
      end
    end
  end

  logic [SW-1:0] lenW, scaled, offs, offsAdj, sumW, wrapped;
  logic          resultErr;

  always_comb begin
    lenW      = {2'b0, selLen};
    scaled    = (lenW << 1) + lenW;
    offs      = scaled >> 2;
    offsAdj   = (offs != '0) ? offs - 1'b1 : offs;
    sumW      = SW'(selStart) + offsAdj;
    wrapped   = (sumW >= N_W) ? sumW - N_W : sumW;
    resultErr = (selLen == '0) || mergeErr || (wrapped >= N_W);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= '0;
      validQ <= 1'b0;
      errQ   <= 1'b0;
    end else if (ctl.resolve) begin
      phaseQ <= resultErr ? '0 : wrapped[PW-1:0];
      validQ <= !resultErr;
      errQ   <= resultErr;
    end else begin
      validQ <= 1'b0;
      errQ   <= 1'b0;
    end
  end

  assign phaseOut = phaseQ;
  assign validOut = validQ;
  assign errOut   = errQ;

  // R4
  run_len_bounded_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> (int'(curLen) <= int'(stepIdx)));

  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({validOut, errOut}));

  // R10
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!validOut && !errOut) |-> $stable(phaseOut));

  // R8
  err_zero_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> (phaseOut == '0));

endmodule

// File: rtl/phase_window_picker.sv
module phase_window_picker
  import phase_pick_pkg::*;
#(
  parameter int NUM_PHASES = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startIn,
  input  logic [NUM_PHASES-1:0]         maskIn,
  output logic [$clog2(NUM_PHASES)-1:0] phaseOut,
  output logic                          validOut,
  output logic                          errOut
);

  localparam int PW = $clog2(NUM_PHASES);

  ctl_strobes_t  ctl;
  logic [PW-1:0] stepIdx;

  phase_pick_ctrl #(.NUM_PHASES(NUM_PHASES)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .ctl     (ctl),
    .stepIdx (stepIdx)
  );

  phase_pick_dp #(.NUM_PHASES(NUM_PHASES)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .stepIdx  (stepIdx),
    .maskIn   (maskIn),
    .phaseOut (phaseOut),
    .validOut (validOut),
    .errOut   (errOut)
  );

  // R2
  result_after_resolve_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validOut || errOut) |-> $past(ctl.resolve));

endmodule

// File: tb/test_phase_window_picker.sv
module test_phase_window_picker;

  localparam int NP = 16;
  localparam int PW = $clog2(NP);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startIn = 1'b0;
  logic [NP-1:0] maskIn = '0;
  logic [PW-1:0] phaseOut;
  logic          validOut, errOut;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  phase_window_picker #(.NUM_PHASES(NP)) i_phase_window_picker (
    .clk(clk), .rstN(rstN), .startIn(startIn), .maskIn(maskIn),
    .phaseOut(phaseOut), .validOut(validOut), .errOut(errOut)
  );

  // Behavioural reference: list windows, merge across the wrap, pick.
  function automatic void refPick(input logic [NP-1:0] m, output int ph, output bit er);
    int rs[$];
    int rl[$];
    int best, bestLen, pos, last;
    rs = {};
    rl = {};
    for (int i = 0; i < NP; i++) begin
      if (m[i]) begin
        if (i == 0 || !m[i-1]) begin
          rs.push_back(i);
          rl.push_back(1);
        end else begin
          rl[rl.size()-1] = rl[rl.size()-1] + 1;
        end
      end
    end
    er = 1'b0;
    ph = 0;
    if (rs.size() == 0) begin
      er = 1'b1;
      return;
    end
    last = rs.size() - 1;
    if (last > 0 && rs[0] == 0 && rs[last] + rl[last] == NP) begin
      rl[last] = rl[last] + rl[0];
      rl[0] = 0;
      if (rl[last] >= NP) begin
        er = 1'b1;
        return;
      end
    end
    best = 0;
    bestLen = 0;
    for (int r = 0; r < rs.size(); r++) begin
      if (rl[r] > bestLen) begin
        bestLen = rl[r];
        best = r;
      end
    end
    pos = (bestLen * 3) / 4;
    if (pos != 0) pos = pos - 1;
    ph = (rs[best] + pos) % NP;
  endfunction

  // Cycle model of the interface.
  int countdown = 0;
  logic [NP-1:0] heldMask = '0;
  bit expValid = 1'b0, expErr = 1'b0;
  int expPhase = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      countdown = 0;
      expValid = 1'b0;
      expErr = 1'b0;
      expPhase = 0;
    end else begin
      expValid = 1'b0;
      expErr = 1'b0;
      if (countdown == 0) begin
        if (startIn) begin
          heldMask = maskIn;
          countdown = NP + 1;
        end
      end else begin
        countdown = countdown - 1;
        if (countdown == 0) begin
          int p;
          bit e;
          refPick(heldMask, p, e);
          expValid = !e;
          expErr = e;
          expPhase = e ? 0 : p;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(validOut == expValid, "R2", "validOut", int'(validOut), int'(expValid));
      check(errOut == expErr, (expErr ? "R8" : "R2"), "errOut", int'(errOut), int'(expErr));
      check(!(validOut && errOut), "R9", "both flags", int'({validOut, errOut}), 1);
      check(int'(phaseOut) == expPhase, ((validOut || errOut) ? curReq : "R10"),
            "phaseOut", int'(phaseOut), expPhase);
    end
  end

  task automatic runMask(input logic [NP-1:0] m, input string req);
    @(negedge clk);
    curReq = req;
    maskIn = m;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    maskIn = ~m;
    repeat (NP + 2) @(negedge clk);
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(validOut == 1'b0, "R1", "validOut in reset", int'(validOut), 0);
    check(errOut == 1'b0, "R1", "errOut in reset", int'(errOut), 0);
    check(phaseOut == '0, "R1", "phaseOut in reset", int'(phaseOut), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runMask(16'h00F0, "R4");   // phase 6
    runMask(16'h0400, "R4");   // single phase 10
    runMask(16'h07F8, "R4");   // phases 3..10, 3+5 = 8
    runMask(16'h0F0F, "R5");   // tie, first wins: 2
    runMask(16'h5555, "R5");   // all length 1: 0
    runMask(16'hC003, "R6");   // merged 14,15,0,1: wraps to 0
    runMask(16'h8001, "R6");   // merged 15,0: 15
    runMask(16'hC0F3, "R6");   // merged ties interior: interior 6
    runMask(16'hE0F3, "R6");   // merged 5 beats 4: 13+2 = 15
    runMask(16'hFFFF, "R7");   // 11
    runMask(16'h0000, "R8");   // error
    runMask(16'h7FFF, "R4");   // 0..14, 15 long: 10

    // R3: start pulses during a scan must not disturb the captured mask
    @(negedge clk);
    curReq = "R3";
    maskIn = 16'h0380;
    startIn = 1'b1;
    @(negedge clk);
    maskIn = 16'h0000;
    repeat (4) @(negedge clk);
    startIn = 1'b1;
    maskIn = 16'hFFFF;
    @(negedge clk);
    startIn = 1'b0;
    repeat (NP + 2) @(negedge clk);

    // R2 back-to-back starts right after each result
    for (int k = 0; k < 3; k++) begin
      curReq = "R2";
      maskIn = 16'h0FF0 >> k;
      startIn = 1'b1;
      repeat (NP + 2) @(negedge clk);
    end
    startIn = 1'b0;
    repeat (NP + 2) @(negedge clk);

    // Randomised masks, edge bits biased on for wrap coverage
    for (int k = 0; k < 60; k++) begin
      logic [NP-1:0] m;
      m = NP'($urandom);
      if (k % 3 == 0) m = m | 16'h8001;
      if (k % 7 == 0) m = m & NP'($urandom);
      runMask(m, "R6");
    end

    finishRun();
  end

endmodule